// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer with Completion Polling

This block sits on the host side of a parallel NOR-style flash bus. A requester hands it one job at a time: a single-word program, a sector erase or a whole-array erase, together with an address and a data word. The sequencer drives the unlock and command write cycles on the flash bus, one bus cycle per clock. It then reads the target location over and over until the device reports that the internal operation has finished, and finally returns a one-cycle done pulse with a pass/fail flag.

Completion can be detected in one of two ways, chosen for each job. In data-polarity mode, bit 7 of the polled word is compared with the bit 7 the finished word should have. In toggle mode, bit 6 is compared across two consecutive reads. The end of the internal operation is not synchronised to the host, so a status read can land right on the boundary. For this reason a first sign of completion is never trusted alone: two confirming reads follow, and both must return the full expected word. A poll budget makes sure that a device which never finishes still produces a failure result.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset and whenever the sequencer is idle, chip enable, output enable and write enable are all high (inactive), `reqReady` is high and `doneValid` is low.
- R2: A job is taken only on a clock edge where `reqValid` and `reqReady` are both high. `reqReady` is low from the cycle after acceptance until the sequencer is idle again, and a request presented while it is low has no effect.
- R3: A program job (`reqOp` = 0) issues exactly four write cycles on consecutive clocks: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (`reqAddr`, `reqData`). Each write cycle has chip enable and write enable low and output enable high, and command bytes are zero-extended to the data width.
- R4: A sector erase (`reqOp` = 1) issues six write cycles: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (`reqAddr`, 30h). A chip erase (`reqOp` = 2) issues the same first five cycles, then (5555h, 10h).
- R5: Polling starts only after the last write cycle. Every poll or confirming read has chip enable and output enable low, write enable high and the address equal to `reqAddr`, and no write cycle occurs once reading has begun.
- R6: In data-polarity mode (`reqToggle` = 0), a poll read indicates completion when its bit 7 equals bit 7 of the expected word. The expected word is `reqData` for a program and all ones for either erase.
- R7: In toggle mode (`reqToggle` = 1), a poll read indicates completion when its bit 6 equals bit 6 of the previous poll read of the same job. The first poll read of a job never indicates completion.
- R8: After an indication, exactly two further reads follow. `doneOk` is 1 only if both of these reads return the full expected word, and 0 otherwise.
- R9: If `TIMEOUT_POLLS` poll reads give no indication, the job ends with `doneOk` = 0 and no confirming reads.
- R10: `doneValid` is high for exactly one cycle per job, and the sequencer is idle in the following cycle.
- R11: `reqOp` = 3 is an invalid job. It is accepted, produces no bus cycle, and ends with `doneValid` in the next cycle and `doneOk` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Job request valid |
| reqReady | output | 1 | Sequencer idle and able to take a job |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 invalid |
| reqAddr | input | ADDR_W | Target word address or sector address |
| reqData | input | DATA_W | Word to program |
| reqToggle | input | 1 | 1 selects toggle-bit detection, 0 selects bit-7 polarity detection |
| doneValid | output | 1 | One-cycle job completion pulse |
| doneOk | output | 1 | Job result, valid with doneValid |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashWeN | output | 1 | Flash write enable, active low |
| flashAddr | output | ADDR_W | Flash address |
| flashWdata | output | DATA_W | Flash write data |
| flashRdata | input | DATA_W | Flash read data, sampled at the end of each read cycle |

## Verification
Some properties are checked on every clock: the strobe rules (idle bus when ready, never a read and a write at once, chip enable present on any access), the handshake turning busy after acceptance, the single-cycle done pulse, and a fixed address across back-to-back reads. The exact command sequences, the choice between the two completion rules, the two confirming reads that turn a boundary hit into a pass or a reject, and the poll budget are outcome-level behaviours. Only the bench's flash model can show these, by varying how long the device stays busy and what it finally returns.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM = 2'd0,
    OP_SECTOR  = 2'd1,
    OP_CHIP    = 2'd2,
    OP_INVALID = 2'd3
  } seq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_POLL,
    ST_CONFIRM,
    ST_DONE
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture the request
    logic wrCycle;  // a command write cycle is on the bus
    logic pollRead; // a poll read is on the bus
  } seq_strobe_t;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_WORD   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] CMD_ARRAY  = 8'h10;

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int TIMEOUT_POLLS = 64,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strb,
  input  logic [2:0]        stepIdx,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqToggle,
  input  logic [DATA_W-1:0] flashRdata,
  output seq_op_e           heldOp,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashWdata,
  output logic              statusHit,
  output logic              wordValid,
  output logic              timedOut
);

  localparam int CNT_W = (TIMEOUT_POLLS > 1) ? $clog2(TIMEOUT_POLLS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_POLLS - 1);

  seq_op_e           opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              toggleQ;
  logic              prevBit6Q;
  logic              havePrevQ;
  logic [CNT_W-1:0]  pollCntQ;

  logic [ADDR_W-1:0] stepAddr;
  logic [DATA_W-1:0] stepData;
  logic [DATA_W-1:0] expWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ       <= OP_PROGRAM;
      addrQ     <= '0;
      dataQ     <= '0;
      toggleQ   <= 1'b0;
      prevBit6Q <= 1'b0;
      havePrevQ <= 1'b0;
      pollCntQ  <= '0;
    end else if (strb.load) begin
      opQ       <= seq_op_e'(reqOp);
      addrQ     <= reqAddr;
      dataQ     <= reqData;
      toggleQ   <= reqToggle;
      havePrevQ <= 1'b0;
      pollCntQ  <= '0;
    end else if (strb.pollRead) begin
      prevBit6Q <= flashRdata[6];
      havePrevQ <= 1'b1;
      pollCntQ  <= pollCntQ + 1'b1;
    end
  end

  // command step table, indexed by the control's step counter
  always_comb begin
    stepAddr = KEY_ADDR_A;
    stepData = DATA_W'(CMD_KEY1);
    unique case (stepIdx)
      3'd0: begin stepAddr = KEY_ADDR_A; stepData = DATA_W'(CMD_KEY1); end
      3'd1: begin stepAddr = KEY_ADDR_B; stepData = DATA_W'(CMD_KEY2); end
      3'd2: begin
        stepAddr = KEY_ADDR_A;
        stepData = (opQ == OP_PROGRAM) ? DATA_W'(CMD_WORD) : DATA_W'(CMD_ERASE);
      end
      3'd3: begin
        if (opQ == OP_PROGRAM) begin
          stepAddr = addrQ;
          stepData = dataQ;
        end else begin
          stepAddr = KEY_ADDR_A;
          stepData = DATA_W'(CMD_KEY1);
        end
      end
      3'd4: begin stepAddr = KEY_ADDR_B; stepData = DATA_W'(CMD_KEY2); end
      default: begin
        if (opQ == OP_SECTOR) begin
          stepAddr = addrQ;
          stepData = DATA_W'(CMD_SECTOR);
        end else begin
          stepAddr = KEY_ADDR_A;
          stepData = DATA_W'(CMD_ARRAY);
        end
      end
    endcase
  end

  assign expWord    = (opQ == OP_PROGRAM) ? dataQ : '1;
  assign flashAddr  = strb.wrCycle ? stepAddr : addrQ;
  assign flashWdata = strb.wrCycle ? stepData : '0;

  assign statusHit = toggleQ ? (havePrevQ && (flashRdata[6] == prevBit6Q))
                             : (flashRdata[7] == expWord[7]);
  assign wordValid = (flashRdata == expWord);
  assign timedOut  = (pollCntQ == CNT_LAST);
  assign heldOp    = opQ;

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  seq_op_e     heldOp,
  input  logic        statusHit,
  input  logic        wordValid,
  input  logic        timedOut,
  output seq_strobe_t strb,
  output logic [2:0]  stepIdx,
  output logic        reqReady,
  output logic        doneValid,
  output logic        doneOk,
  output logic        flashCeN,
  output logic        flashOeN,
  output logic        flashWeN
);

  seq_state_e stateQ;
  logic [2:0] stepQ;
  logic       confSecondQ;
  logic       confOkQ;
  logic       okQ;
  logic [2:0] lastStep;

  assign lastStep = (heldOp == OP_PROGRAM) ? 3'd3 : 3'd5;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      stepQ       <= '0;
      confSecondQ <= 1'b0;
      confOkQ     <= 1'b0;
      okQ         <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (reqValid) begin
            stepQ <= '0;
            okQ   <= 1'b0;
            if (seq_op_e'(reqOp) == OP_INVALID) stateQ <= ST_DONE;
            else                               stateQ <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (stepQ == lastStep) stateQ <= ST_POLL;
          else                   stepQ  <= stepQ + 3'd1;
        end
        ST_POLL: begin
          if (statusHit) begin
            stateQ      <= ST_CONFIRM;
            confSecondQ <= 1'b0;
          end else if (timedOut) begin
            stateQ <= ST_DONE;
            okQ    <= 1'b0;
          end
        end
        ST_CONFIRM: begin
          if (!confSecondQ) begin
            confSecondQ <= 1'b1;
            confOkQ     <= wordValid;
          end else begin
            stateQ <= ST_DONE;
            okQ    <= confOkQ && wordValid;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.load     = (stateQ == ST_IDLE) && reqValid;
    strb.wrCycle  = (stateQ == ST_WRITE);
    strb.pollRead = (stateQ == ST_POLL);
  end

  assign stepIdx   = stepQ;
  assign reqReady  = (stateQ == ST_IDLE);
  assign doneValid = (stateQ == ST_DONE);
  assign doneOk    = okQ;
  assign flashWeN  = (stateQ != ST_WRITE);
  assign flashOeN  = !((stateQ == ST_POLL) || (stateQ == ST_CONFIRM));
  assign flashCeN  = flashWeN && flashOeN;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int TIMEOUT_POLLS = 64,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqToggle,
  output logic              doneValid,
  output logic              doneOk,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashWdata,
  input  logic [DATA_W-1:0] flashRdata
);

  seq_strobe_t strb;
  logic [2:0]  stepIdx;
  seq_op_e     heldOp;
  logic        statusHit;
  logic        wordValid;
  logic        timedOut;

  flash_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .heldOp    (heldOp),
    .statusHit (statusHit),
    .wordValid (wordValid),
    .timedOut  (timedOut),
    .strb      (strb),
    .stepIdx   (stepIdx),
    .reqReady  (reqReady),
    .doneValid (doneValid),
    .doneOk    (doneOk),
    .flashCeN  (flashCeN),
    .flashOeN  (flashOeN),
    .flashWeN  (flashWeN)
  );

  flash_seq_dp #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .TIMEOUT_POLLS (TIMEOUT_POLLS),
    .KEY_ADDR_A    (KEY_ADDR_A),
    .KEY_ADDR_B    (KEY_ADDR_B)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .stepIdx    (stepIdx),
    .reqOp      (reqOp),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .reqToggle  (reqToggle),
    .flashRdata (flashRdata),
    .heldOp     (heldOp),
    .flashAddr  (flashAddr),
    .flashWdata (flashWdata),
    .statusHit  (statusHit),
    .wordValid  (wordValid),
    .timedOut   (timedOut)
  );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              doneValid,
  input logic              flashCeN,
  input logic              flashOeN,
  input logic              flashWeN,
  input logic [ADDR_W-1:0] flashAddr
);

  assert_idle_bus_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (flashCeN && flashOeN && flashWeN));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_no_ready_with_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !reqReady);

  assert_no_read_write_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashOeN && !flashWeN));

  assert_access_selects_chip_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN || !flashOeN) |-> !flashCeN);

  assert_read_addr_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!flashOeN && $past(!flashOeN)) |-> $stable(flashAddr));

  assert_done_single_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .doneValid (doneValid),
  .flashCeN  (flashCeN),
  .flashOeN  (flashOeN),
  .flashWeN  (flashWeN),
  .flashAddr (flashAddr)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;

  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic        reqToggle = 1'b0;
  logic        doneValid;
  logic        doneOk;
  logic        flashCeN, flashOeN, flashWeN;
  logic [15:0] flashAddr, flashWdata;
  logic [15:0] flashRdata;

  always #2 clk = ~clk;

  flash_cmd_seq #(.TIMEOUT_POLLS(TMO)) u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .reqToggle(reqToggle),
    .doneValid(doneValid), .doneOk(doneOk),
    .flashCeN(flashCeN), .flashOeN(flashOeN), .flashWeN(flashWeN),
    .flashAddr(flashAddr), .flashWdata(flashWdata), .flashRdata(flashRdata)
  );

  // ---------------- flash model ----------------
  logic [1:0]  curOp = 2'd0;
  logic [15:0] curData = '0;
  logic [15:0] curFinal = '0;
  int          curBusy = 0;

  int          busyLeft = 0;
  logic        tglQ = 1'b0;
  int          wrCount = 0;
  int          rdCount = 0;
  int          wrAfterRd = 0;
  int          doneCnt = 0;
  logic [15:0] wrA [8];
  logic [15:0] wrD [8];

  always @(posedge clk) begin
    if (reqValid && reqReady) begin
      busyLeft  <= curBusy;
      tglQ      <= 1'b0;
      wrCount   <= 0;
      rdCount   <= 0;
      wrAfterRd <= 0;
    end else begin
      if (!flashCeN && !flashWeN) begin
        if (wrCount < 8) begin
          wrA[wrCount] <= flashAddr;
          wrD[wrCount] <= flashWdata;
        end
        wrCount <= wrCount + 1;
        if (rdCount > 0) wrAfterRd <= wrAfterRd + 1;
      end
      if (!flashCeN && !flashOeN) begin
        rdCount <= rdCount + 1;
        tglQ    <= ~tglQ;
        if (busyLeft > 0) busyLeft <= busyLeft - 1;
      end
    end
    if (doneValid) doneCnt <= doneCnt + 1;
  end

  always_comb begin
    if (busyLeft > 0) begin
      if (curOp == 2'd0) begin
        flashRdata    = curData;
        flashRdata[7] = ~curData[7];
      end else begin
        flashRdata = '0;
      end
      flashRdata[6] = tglQ;
    end else begin
      flashRdata = curFinal;
    end
  end

  // ---------------- bookkeeping ----------------
  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input logic [1:0] op, input logic [15:0] d);
    return (op == 2'd0) ? d : 16'hFFFF;
  endfunction

  function automatic int pollsNeeded(input logic [1:0] op, input logic tgl,
                                     input logic [15:0] d, input int busy,
                                     input logic [15:0] fin);
    logic [15:0] ew = expWord(op, d);
    if (!tgl) return (fin[7] == ew[7]) ? busy + 1 : 100000;
    if (busy == 0) return 2;
    return (fin[6] == logic'((busy - 1) & 1)) ? busy + 1 : busy + 2;
  endfunction

  task automatic expStep(input logic [1:0] op, input int i, input logic [15:0] a,
                         input logic [15:0] d, output logic [15:0] ea, output logic [15:0] ed);
    case (i)
      0: begin ea = 16'h5555; ed = 16'h00AA; end
      1: begin ea = 16'h2AAA; ed = 16'h0055; end
      2: begin ea = 16'h5555; ed = (op == 2'd0) ? 16'h00A0 : 16'h0080; end
      3: begin
        if (op == 2'd0) begin ea = a; ed = d; end
        else begin ea = 16'h5555; ed = 16'h00AA; end
      end
      4: begin ea = 16'h2AAA; ed = 16'h0055; end
      default: begin
        if (op == 2'd1) begin ea = a; ed = 16'h0030; end
        else begin ea = 16'h5555; ed = 16'h0010; end
      end
    endcase
  endtask

  task automatic issue(input logic [1:0] op, input logic tgl, input logic [15:0] a,
                       input logic [15:0] d, input int busy, input logic [15:0] fin);
    @(negedge clk);
    curOp = op; curData = d; curBusy = busy; curFinal = fin;
    reqOp = op; reqToggle = tgl; reqAddr = a; reqData = d; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output bit seen, output logic ok);
    seen = 1'b0; ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (doneValid) begin seen = 1'b1; ok = doneOk; break; end
      @(negedge clk);
    end
  endtask

  // ---------------- vectors ----------------
  typedef struct packed {
    logic [1:0]  op;
    logic        tgl;
    logic [15:0] addr;
    logic [15:0] data;
    logic [15:0] busy;
    logic [15:0] fin;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 16'h1234, 16'h00A5, 16'd3,    16'h00A5}, // program, polarity
    '{2'd0, 1'b1, 16'h0F00, 16'h5A3C, 16'd4,    16'h5A3C}, // program, toggle
    '{2'd1, 1'b0, 16'h7800, 16'h0000, 16'd5,    16'hFFFF}, // sector, polarity
    '{2'd2, 1'b1, 16'h0000, 16'h0000, 16'd2,    16'hFFFF}, // chip, toggle
    '{2'd0, 1'b0, 16'h0042, 16'h1280, 16'd2,    16'h1281}, // boundary reject
    '{2'd0, 1'b0, 16'h0100, 16'h0033, 16'd1000, 16'h0033}, // timeout polarity
    '{2'd1, 1'b1, 16'hF800, 16'h0000, 16'd1000, 16'hFFFF}, // timeout toggle
    '{2'd0, 1'b0, 16'h0007, 16'hFFFF, 16'd0,    16'hFFFF}, // done at first read
    '{2'd1, 1'b0, 16'h3000, 16'h0000, 16'd1,    16'hFEFF}  // erase reject
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit seen;
    logic ok;
    int d0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(flashCeN && flashOeN && flashWeN, "R1 bus idle in reset", {flashCeN, flashOeN, flashWeN}, 7);
    check(!doneValid, "R1 done low in reset", doneValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R1 ready after reset", reqReady, 1);
    check(flashCeN && flashOeN && flashWeN, "R1 bus idle after reset", {flashCeN, flashOeN, flashWeN}, 7);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      int need = pollsNeeded(t.op, t.tgl, t.data, int'(t.busy), t.fin);
      int expReads = (need > TMO) ? TMO : need + 2;
      logic expOk = (need <= TMO) && (t.fin == expWord(t.op, t.data));
      int expWr = (t.op == 2'd0) ? 4 : 6;
      bit seqOk = 1'b1;
      issue(t.op, t.tgl, t.addr, t.data, int'(t.busy), t.fin);
      waitDone(seen, ok);
      check(seen, $sformatf("R10 vec%0d done seen", v), seen, 1);
      check(ok == expOk, $sformatf("R6 R7 R8 R9 vec%0d result", v), ok, expOk);
      check(rdCount == expReads, $sformatf("R8 R9 vec%0d read count", v), rdCount, expReads);
      check(wrCount == expWr, $sformatf("R3 R4 vec%0d write count", v), wrCount, expWr);
      for (int i = 0; i < expWr && i < 8; i++) begin
        logic [15:0] ea, ed;
        expStep(t.op, i, t.addr, t.data, ea, ed);
        if (wrA[i] !== ea || wrD[i] !== ed) seqOk = 1'b0;
      end
      check(seqOk, $sformatf("R3 R4 vec%0d write sequence", v), seqOk, 1);
      check(wrAfterRd == 0, $sformatf("R5 vec%0d no write after read", v), wrAfterRd, 0);
      @(negedge clk);
      check(!doneValid && reqReady, $sformatf("R10 vec%0d single pulse", v), {doneValid, reqReady}, 1);
    end

    // R2: request held while busy is ignored
    d0 = doneCnt;
    issue(2'd0, 1'b0, 16'h0200, 16'h0011, 10, 16'h0011);
    repeat (2) @(negedge clk);
    reqOp = 2'd2; reqValid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      check(!reqReady, "R2 not ready while busy", reqReady, 0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    waitDone(seen, ok);
    check(seen && ok, "R2 original job completes", ok, 1);
    check(wrCount == 4, "R2 busy request adds no writes", wrCount, 4);
    @(negedge clk);
    check(doneCnt == d0 + 1, "R2 one done per accepted job", doneCnt - d0, 1);

    // R11 invalid opcode
    issue(2'd3, 1'b0, 16'h0000, 16'h0000, 0, 16'h0000);
    check(doneValid && !doneOk, "R11 invalid op fails at once", {doneValid, doneOk}, 2);
    check(wrCount == 0 && rdCount == 0, "R11 invalid op no bus cycles", wrCount + rdCount, 0);
    @(negedge clk);
    check(reqReady && flashCeN, "R1 idle after invalid op", {reqReady, flashCeN}, 3);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule